// File: doc/BRIEF.md
# Video Memory Wait-State Generator

This block produces the READY handshake that a CPU sees when it reaches into video memory that a display controller shares with it. Everything runs on one master dot clock. Inside, a divider marks the start of each CPU cycle once every 3 dots, and a 4-bit character-phase counter wraps every 16 dots. How long the CPU is held depends only on where its cycle falls within the 16-dot character.

A request can start a wait only on a dot that begins a CPU cycle. The wait then runs through three stages in order. First a fixed half-character delay of 8 dots. Next a hold until the first character boundary that lies strictly beyond that delay. Last a hold until the next CPU-cycle boundary, which may fall on the same dot. READY then returns high. On that same dot a one-dot done pulse appears, and the wait length in CPU cycles is presented. The display raster has no effect on the wait, so the same rule holds during active video, overscan and retrace. A phase-offset input, loaded during reset, sets the starting value of the character counter so that every relative phase can be reached.

Top module: `vwait_gen`

## Requirements
- R1: While reset is active and on the first dot after it: ready is 1, done is 0, wait_count is 0, char_phase equals phase_init and cpu_clk_en is 1.
- R2: cpu_clk_en is 1 on exactly one dot in every 3, starting with the first dot after reset. char_phase rises by one each dot and goes from 15 back to 0.
- R3: A request is taken only on a dot where req, cpu_clk_en and ready are all 1. On the following dot ready reads 0. If req is high on a dot where cpu_clk_en is 0 while the block is idle, ready stays 1.
- R4: Count dots from the dot on which the request is taken (offset 0). Let d1 be the first offset above 8 at which char_phase reads 0. Let d2 be the first offset at or above d1 at which cpu_clk_en reads 1. Ready is then 0 on offsets 1 through d2 and returns to 1 on offset d2+1.
- R5: done is 1 for exactly one dot, the dot on which ready returns to 1. On that dot wait_count equals d2/3, so ready was low for 3×wait_count dots. wait_count holds its value until the next done.
- R6: Let p be the char_phase value on the dot a request is taken. p=7 gives a wait of 3. Each of the waits 4, 5, 6, 7 and 8 comes from exactly three values of p. No other wait length occurs.
- R7: Over all 16 values of p, the waits add up to 93, which is an average of 5.8125 CPU cycles.
- R8: A req pulse that arrives while ready is 0 is ignored. The wait in progress finishes with its normal length, and no second wait follows it.
- R9: The wait length depends only on p, never on how long the block has been running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_init | input | 4 | Character-phase value loaded while reset is active |
| req | input | 1 | CPU request for video memory |
| ready | output | 1 | 0 while the CPU is being held |
| done | output | 1 | One-dot pulse on the dot ready returns to 1 |
| wait_count | output | 4 | Length of the last wait, in CPU cycles |
| cpu_clk_en | output | 1 | 1 on the first dot of each CPU cycle |
| char_phase | output | 4 | Dot position within the 16-dot character |

## Verification
The hardest thing to reach from the ports is the full set of 16 relative phases. Since requests only land on CPU-cycle dots, a free-running block visits the phases in a fixed order that depends on time. The bench therefore resets the block once for each value of phase_init and issues a request on the very first dot. This sweep gives every phase exactly once, so the histogram and the sum of 93 can be checked. A separate run with an irregular gap between requests then confirms that the wait length depends only on phase. Another run injects a req pulse on a CPU-cycle dot in the middle of a wait, to show that the pulse is dropped.

// File: rtl/vwait_pkg.sv
// Package: shared types for the video memory wait-state generator.
// Assumes: nothing beyond standard SystemVerilog.
package vwait_pkg;

    // States of the wait sequence
    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_HALF  = 2'd1,
        WS_CHAR  = 2'd2,
        WS_ALIGN = 2'd3
    } wstate_t;

endpackage

// File: rtl/vwait_timebase.sv
// Module: vwait_timebase
// Derives the CPU cycle enable (one dot in CPU_DOTS) and the character
// phase counter (wraps every CHAR_DOTS dots) from the master dot clock.
// Assumes: both counters restart on reset; the phase loads phase_init.
module vwait_timebase #(
    parameter int CPU_DOTS  = 3,
    parameter int CHAR_DOTS = 16,
    parameter int PH_W      = $clog2(CHAR_DOTS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PH_W-1:0] phase_init,
    output logic            cpu_en,
    output logic            char_zero,
    output logic [PH_W-1:0] phase
);
    localparam int DIV_W = $clog2(CPU_DOTS);

    logic [DIV_W-1:0] div_q;

    // Advance the CPU divider and the character phase by one dot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            phase <= phase_init;
        end else begin
            div_q <= (div_q == DIV_W'(CPU_DOTS - 1)) ? '0 : div_q + 1'b1;
            phase <= (phase == PH_W'(CHAR_DOTS - 1)) ? '0 : phase + 1'b1;
        end
    end

    assign cpu_en    = (div_q == '0);
    assign char_zero = (phase == '0);

    a_r2_char_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_W'(CHAR_DOTS - 1)) |=> (phase == '0));
    a_r2_cpu_single: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |=> !cpu_en);

endmodule

// File: rtl/vwait_seq.sv
// Module: vwait_seq
// Three-stage wait sequencer: half character, then the next character
// boundary strictly after it, then the next CPU cycle boundary.
// Assumes: cpu_en and char_zero come from vwait_timebase on the same clock.
module vwait_seq
    import vwait_pkg::*;
#(
    parameter int HALF_DOTS = 8,
    parameter int HC_W      = $clog2(HALF_DOTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic cpu_en,
    input  logic char_zero,
    output logic ready,
    output logic start,
    output logic finish,
    output logic busy
);
    wstate_t         state;
    logic [HC_W-1:0] half_cnt;

    assign start  = (state == WS_IDLE) && req && cpu_en;
    assign finish = ((state == WS_CHAR) && char_zero && cpu_en) ||
                    ((state == WS_ALIGN) && cpu_en);
    assign busy   = (state != WS_IDLE);

    // Step the wait stages and drive the READY register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= WS_IDLE;
            half_cnt <= '0;
            ready    <= 1'b1;
        end else begin
            case (state)
                WS_IDLE: if (start) begin
                    state    <= WS_HALF;
                    half_cnt <= HC_W'(1);
                    ready    <= 1'b0;
                end
                WS_HALF: if (half_cnt == HC_W'(HALF_DOTS)) begin
                    state <= WS_CHAR;
                end else begin
                    half_cnt <= half_cnt + 1'b1;
                end
                WS_CHAR: if (char_zero) begin
                    if (cpu_en) begin
                        state <= WS_IDLE;
                        ready <= 1'b1;
                    end else begin
                        state <= WS_ALIGN;
                    end
                end
                WS_ALIGN: if (cpu_en) begin
                    state <= WS_IDLE;
                    ready <= 1'b1;
                end
                default: state <= WS_IDLE;
            endcase
        end
    end

    a_r3_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && req && cpu_en) |=> !ready);
    a_r8_busy_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ready);
    a_r4_release_after_cpu_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(cpu_en));

endmodule

// File: rtl/vwait_cyc_counter.sv
// Module: vwait_cyc_counter
// Counts CPU cycle boundaries seen during a wait; saturates at its maximum.
// Assumes: clear and inc are never both needed on the same dot.
module vwait_cyc_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    // Clear at the start of a wait, else count CPU boundaries
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (inc && (count != {CNT_W{1'b1}})) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/vwait_gen.sv
// Module: vwait_gen (top)
// Video memory wait-state generator: holds READY low for a wait whose length
// follows from the CPU-cycle phase relative to the character clock, then
// reports the length in CPU cycles with a one-dot done pulse.
// Assumes: single dot clock, synchronous active-low reset.
module vwait_gen #(
    parameter int CPU_DOTS  = 3,
    parameter int CHAR_DOTS = 16,
    parameter int CNT_W     = 4,
    parameter int PH_W      = $clog2(CHAR_DOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PH_W-1:0]  phase_init,
    input  logic             req,
    output logic             ready,
    output logic             done,
    output logic [CNT_W-1:0] wait_count,
    output logic             cpu_clk_en,
    output logic [PH_W-1:0]  char_phase
);
    localparam int HALF_DOTS = CHAR_DOTS / 2;

    logic             char_zero;
    logic             start;
    logic             finish;
    logic             busy;
    logic [CNT_W-1:0] cyc_cnt;

    vwait_timebase #(.CPU_DOTS(CPU_DOTS), .CHAR_DOTS(CHAR_DOTS), .PH_W(PH_W)) tb_i (
        .clk(clk), .rst_n(rst_n), .phase_init(phase_init),
        .cpu_en(cpu_clk_en), .char_zero(char_zero), .phase(char_phase)
    );

    vwait_seq #(.HALF_DOTS(HALF_DOTS)) seq_i (
        .clk(clk), .rst_n(rst_n), .req(req), .cpu_en(cpu_clk_en),
        .char_zero(char_zero), .ready(ready), .start(start),
        .finish(finish), .busy(busy)
    );

    vwait_cyc_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .clear(start),
        .inc(busy && cpu_clk_en), .count(cyc_cnt)
    );

    // Publish the wait length and the done pulse as READY returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done       <= 1'b0;
            wait_count <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                wait_count <= cyc_cnt + 1'b1;
            end
        end
    end

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ready && !$past(ready)));
    a_r6_wait_range: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wait_count >= CNT_W'(3) && wait_count <= CNT_W'(8)));

endmodule

// File: tb/vwait_gen_tb_top.sv
// Directed bench for vwait_gen; one task per scenario, each self-checking.
module vwait_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] phase_init = 4'd0;
    logic       req = 1'b0;
    logic       ready, done, cpu_clk_en;
    logic [3:0] wait_count, char_phase;

    int n_tests = 0;
    int n_fail  = 0;
    int dot     = 0;
    int init_ph = 0;

    always #2.5 clk = ~clk;

    vwait_gen dut_i (
        .clk(clk), .rst_n(rst_n), .phase_init(phase_init), .req(req),
        .ready(ready), .done(done), .wait_count(wait_count),
        .cpu_clk_en(cpu_clk_en), .char_phase(char_phase)
    );

    // Dot index: 0 on the dot after the last reset edge
    always @(posedge clk) begin
        if (!rst_n) dot <= 0;
        else        dot <= dot + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int model_wait(input int p);
        int x, d1, d2;
        x = (8 - p) & 15;
        if (x == 0) x = 16;
        d1 = 8 + x;
        d2 = ((d1 + 2) / 3) * 3;
        return d2 / 3;
    endfunction

    task automatic do_reset(input int ph);
        @(negedge clk);
        rst_n = 1'b0;
        phase_init = 4'(ph);
        init_ph = ph;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Issue one request on the next CPU boundary and measure the low time
    task automatic issue(input bit inject, output int lowcnt, output int p);
        bit injected;
        injected = 1'b0;
        while (dot % 3 != 0) @(negedge clk);
        p = (init_ph + dot) % 16;
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        lowcnt = 0;
        while (!ready && lowcnt < 100) begin
            if (inject && !injected && lowcnt >= 2 && dot % 3 == 0) begin
                req = 1'b1;
                injected = 1'b1;
            end
            lowcnt++;
            @(negedge clk);
            req = 1'b0;
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        phase_init = 4'd9;
        repeat (2) @(negedge clk);
        check(ready == 1'b1, "R1 ready in reset", ready, 1);
        check(done == 1'b0, "R1 done in reset", done, 0);
        check(wait_count == 4'd0, "R1 wait_count in reset", wait_count, 0);
        check(char_phase == 4'd9, "R1 char_phase loads phase_init", char_phase, 9);
        check(cpu_clk_en == 1'b1, "R1 cpu divider at zero", cpu_clk_en, 1);
        init_ph = 9;
        rst_n = 1'b1;
    endtask

    task automatic t_timebase();
        bit ok_en, ok_ph;
        ok_en = 1'b1;
        ok_ph = 1'b1;
        for (int i = 0; i < 40; i++) begin
            if (cpu_clk_en != (dot % 3 == 0)) ok_en = 1'b0;
            if (int'(char_phase) != (init_ph + dot) % 16) ok_ph = 1'b0;
            @(negedge clk);
        end
        check(ok_en, "R2 cpu_clk_en once per 3 dots", ok_en, 1);
        check(ok_ph, "R2 char_phase counts and wraps", ok_ph, 1);
    endtask

    task automatic t_sweep();
        int hist[9];
        int sum, lc, p, e, wc;
        bit ok_r4, ok_r5, ok_pulse, ok_hold;
        sum = 0;
        ok_r4 = 1'b1; ok_r5 = 1'b1; ok_pulse = 1'b1; ok_hold = 1'b1;
        for (int i = 0; i < 9; i++) hist[i] = 0;
        for (int k = 0; k < 16; k++) begin
            do_reset(k);
            issue(1'b0, lc, p);
            e = model_wait(p);
            if (lc != 3 * e) begin
                ok_r4 = 1'b0;
                $display("FAIL R4 phase %0d low dots: actual %0d expected %0d", p, lc, 3 * e);
            end
            if (!done || int'(wait_count) != e) begin
                ok_r5 = 1'b0;
                $display("FAIL R5 phase %0d wait_count: actual %0d expected %0d", p, wait_count, e);
            end
            wc = int'(wait_count);
            sum += wc;
            if (wc >= 0 && wc <= 8) hist[wc]++;
            if (p == 7 && wc != 3) ok_r4 = 1'b0;
            @(negedge clk);
            if (done) ok_pulse = 1'b0;
            repeat (4) @(negedge clk);
            if (int'(wait_count) != wc || done) ok_hold = 1'b0;
        end
        check(ok_r4, "R4 low duration over all phases", ok_r4, 1);
        check(ok_r5, "R5 wait_count over all phases", ok_r5, 1);
        check(ok_pulse, "R5 done is one dot wide", ok_pulse, 1);
        check(ok_hold, "R5 wait_count held after done", ok_hold, 1);
        check(hist[3] == 1, "R6 single phase gives 3", hist[3], 1);
        for (int w = 4; w <= 8; w++)
            check(hist[w] == 3, $sformatf("R6 three phases give %0d", w), hist[w], 3);
        check(sum == 93, "R7 sum of 16 waits (avg 5.8125)", sum, 93);
    endtask

    task automatic t_accept();
        bit stayed;
        int lc, p;
        do_reset(3);
        while (dot % 3 != 1) @(negedge clk);
        req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        stayed = 1'b1;
        repeat (3) begin
            if (!ready) stayed = 1'b0;
            @(negedge clk);
        end
        check(stayed, "R3 req off a CPU boundary is not taken", stayed, 1);
        issue(1'b0, lc, p);
        check(lc == 3 * model_wait(p), "R3 request on boundary is taken", lc, 3 * model_wait(p));
    endtask

    task automatic t_ignore();
        int lc, p;
        bit high;
        do_reset(11);
        issue(1'b1, lc, p);
        check(lc == 3 * model_wait(p), "R8 wait unaffected by extra req", lc, 3 * model_wait(p));
        check(int'(wait_count) == model_wait(p), "R8 count unaffected by extra req",
              wait_count, model_wait(p));
        high = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (!ready) high = 1'b0;
        end
        check(high, "R8 no second wait after ignored req", high, 1);
    endtask

    task automatic t_raster();
        int lc, p;
        bit ok;
        ok = 1'b1;
        do_reset(5);
        for (int i = 0; i < 40; i++) begin
            repeat ((i * 7) % 11) @(negedge clk);
            issue(1'b0, lc, p);
            if (int'(wait_count) != model_wait(p) || lc != 3 * model_wait(p)) begin
                ok = 1'b0;
                $display("FAIL R9 phase %0d at dot %0d: actual %0d expected %0d",
                         p, dot, wait_count, model_wait(p));
            end
        end
        check(ok, "R9 wait depends only on phase", ok, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_timebase();
        t_sweep();
        t_accept();
        t_ignore();
        t_raster();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule